// File: doc/BRIEF.md
# Infrared Pulse-Width Pattern Receiver

This block decodes a remote-control style serial line that has already been filtered. It times the spacing between successive rising edges of the input in units of a tick enable. Each timed width is then sorted into one of several symbol kinds by testing it against programmable minimum/maximum windows: a header, a data 0, a data 1, or (when enabled) a special symbol that shares the header window. Data symbols shift into a 48-bit receive buffer, with the first bit received at bit 0.

Once the line has been quiet longer than every programmed maximum, the frame is treated as complete. The buffer can also be compared against a stored pattern over a selectable number of low-order bytes. Every event sets its own sticky status flag. A single interrupt request is the OR of the flags whose enable bits are set.

All configuration and status are plain pins. The received buffer and bit count are held levels, not a stream, so there is no valid/ready handshake and no back-pressure. The buffer keeps its contents until the next header arrives. With headers disabled, it keeps them until the first data bit after a completed frame.

Top module: `irpw_rx`

## Requirements
- R1: A rising edge on `ir_in` while measuring latches the number of ticks counted since the previous rising edge as the width, then restarts the count from zero. The first rising edge after reset or after a completed frame only starts measuring and classifies nothing.
- R2: With `hdr_en`=1 and `sd_en`=0, a width w with `hdr_min` <= w <= `hdr_max` (both bounds inclusive) is a header. A header sets status bit 1, empties the buffer and zeroes the bit count.
- R3: A width inside the data-0 window (`d0_min`..`d0_max`) or the data-1 window (`d1_min`..`d1_max`) sets status bit 2 and stores bit value 0 or 1. Each stored bit goes to position `rx_bits` and then the count increments, so the first bit lands at bit 0.
- R4: With `sd_en`=1, a width inside the header window sets status bit 3 instead of status bit 1 and does not empty the buffer. With `hdr_en`=0, data bits are accepted without a header: the first data bit after a completed frame starts a fresh buffer.
- R5: A width that falls in no usable window sets status bit 4 (receive error).
- R6: With `hdr_en`=1, a data-0 or data-1 width arriving before any header since the last completed frame sets status bit 4. That bit is not stored and `rx_bits` is unchanged.
- R7: While measuring, once the running count is greater than all three of `hdr_max`, `d0_max` and `d1_max`, status bit 0 (frame complete) is set and measuring stops.
- R8: When the bit count reaches 48, status bit 5 is set. Further data bits are ignored, and `rx_data` and `rx_bits` stay unchanged.
- R9: After each stored bit, if `rx_data` equals `cmp_val` on the lowest N+1 bytes (N = `cmp_sel`; any N above 5 selects all six bytes), status bit 6 is set.
- R10: When the width count passes 16'hFFFF while measuring and wraps to 16'h0000, status bit 7 is set.
- R11: Status flags are sticky. A cycle with `clr_stb`=1 clears every flag whose `clr_mask` bit is 1 and leaves the others alone. A new event in the same cycle wins over the clear.
- R12: `irq` is 1 exactly when some status bit is 1 and the `int_en` bit at the same position is 1.
- R13: After reset, `status`, `rx_data`, `rx_bits` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Width-count enable |
| ir_in | input | 1 | Filtered remote input |
| hdr_en | input | 1 | Header detection enable |
| sd_en | input | 1 | Special-symbol detection enable |
| hdr_min | input | 16 | Header window lower bound |
| hdr_max | input | 16 | Header window upper bound |
| d0_min | input | 16 | Data-0 window lower bound |
| d0_max | input | 16 | Data-0 window upper bound |
| d1_min | input | 16 | Data-1 window lower bound |
| d1_max | input | 16 | Data-1 window upper bound |
| cmp_val | input | 48 | Compare pattern |
| cmp_sel | input | 3 | Compare byte-count select |
| int_en | input | 8 | Per-flag interrupt enables |
| clr_stb | input | 1 | Flag clear strobe |
| clr_mask | input | 8 | Flags to clear when strobed |
| rx_data | output | 48 | Receive buffer |
| rx_bits | output | 6 | Number of bits stored |
| status | output | 8 | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the pins is the counter wrap. Normally the frame-complete check stops measuring long before 65536 ticks. The stimulus therefore raises all three maxima to 16'hFFFF, so the count can never exceed them, arms the counter with one edge, and idles past the wrap. The ordering error is also awkward to reach, because header state survives until a frame completes. The bench lets a frame finish first and then sends a lone data symbol. Random frames of 1 to 60 bits with random compare selects and random irrelevant upper bytes cover buffer filling, saturation at 48 bits and masked matching.

// File: rtl/irpw_pkg.sv
package irpw_pkg;
  localparam int EV_NUM  = 8;
  localparam int EV_DONE = 0;
  localparam int EV_HDR  = 1;
  localparam int EV_DATA = 2;
  localparam int EV_SPEC = 3;
  localparam int EV_ERR  = 4;
  localparam int EV_FULL = 5;
  localparam int EV_CMP  = 6;
  localparam int EV_OVF  = 7;

  typedef enum logic [2:0] {
    SYM_ERR,
    SYM_HDR,
    SYM_SPEC,
    SYM_D0,
    SYM_D1
  } sym_e;
endpackage

// File: rtl/irpw_width_ctr.sv
// Edge timing: counts ticks between rising edges, flags frame end and wrap.
module irpw_width_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ir_in,
  input  logic [CNT_W-1:0] hdr_max,
  input  logic [CNT_W-1:0] d0_max,
  input  logic [CNT_W-1:0] d1_max,
  output logic [CNT_W-1:0] meas_w,
  output logic             meas_vld,
  output logic             done_ev,
  output logic             ovf_ev
);
  logic             ir_q;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             rise;
  logic             past_all;

  assign rise     = ir_in & ~ir_q;
  assign past_all = (cnt > hdr_max) && (cnt > d0_max) && (cnt > d1_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q     <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      meas_w   <= '0;
      meas_vld <= 1'b0;
      done_ev  <= 1'b0;
      ovf_ev   <= 1'b0;
    end else begin
      ir_q     <= ir_in;
      meas_vld <= 1'b0;
      done_ev  <= 1'b0;
      ovf_ev   <= 1'b0;
      if (rise) begin
        if (armed) begin
          meas_w   <= cnt;
          meas_vld <= 1'b1;
        end
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (past_all) begin
          done_ev <= 1'b1;
          armed   <= 1'b0;
          cnt     <= '0;
        end else if (tick) begin
          cnt <= cnt + CNT_W'(1);
          if (&cnt) ovf_ev <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irpw_classify.sv
// Window classification of a latched width and header-order tracking.
module irpw_classify
  import irpw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] meas_w,
  input  logic             meas_vld,
  input  logic             done_ev,
  input  logic             hdr_en,
  input  logic             sd_en,
  input  logic [CNT_W-1:0] hdr_min,
  input  logic [CNT_W-1:0] hdr_max,
  input  logic [CNT_W-1:0] d0_min,
  input  logic [CNT_W-1:0] d0_max,
  input  logic [CNT_W-1:0] d1_min,
  input  logic [CNT_W-1:0] d1_max,
  output logic             hdr_ev,
  output logic             spec_ev,
  output logic             data_ev,
  output logic             err_ev,
  output logic             bit_vld,
  output logic             bit_val
);
  function automatic logic in_win(input logic [CNT_W-1:0] w,
                                  input logic [CNT_W-1:0] lo,
                                  input logic [CNT_W-1:0] hi);
    return (w >= lo) && (w <= hi);
  endfunction

  sym_e kind;
  logic hdr_seen;
  logic order_bad;

  always_comb begin
    if (in_win(meas_w, hdr_min, hdr_max) && sd_en)       kind = SYM_SPEC;
    else if (in_win(meas_w, hdr_min, hdr_max) && hdr_en) kind = SYM_HDR;
    else if (in_win(meas_w, d0_min, d0_max))             kind = SYM_D0;
    else if (in_win(meas_w, d1_min, d1_max))             kind = SYM_D1;
    else                                                 kind = SYM_ERR;
    order_bad = hdr_en && !hdr_seen && ((kind == SYM_D0) || (kind == SYM_D1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_ev   <= 1'b0;
      spec_ev  <= 1'b0;
      data_ev  <= 1'b0;
      err_ev   <= 1'b0;
      bit_vld  <= 1'b0;
      bit_val  <= 1'b0;
      hdr_seen <= 1'b0;
    end else begin
      hdr_ev  <= 1'b0;
      spec_ev <= 1'b0;
      data_ev <= 1'b0;
      err_ev  <= 1'b0;
      bit_vld <= 1'b0;
      if (done_ev) hdr_seen <= 1'b0;
      if (meas_vld) begin
        case (kind)
          SYM_HDR: begin
            hdr_ev   <= 1'b1;
            hdr_seen <= 1'b1;
          end
          SYM_SPEC: spec_ev <= 1'b1;
          SYM_D0, SYM_D1: begin
            if (order_bad) begin
              err_ev <= 1'b1;
            end else begin
              data_ev <= 1'b1;
              bit_vld <= 1'b1;
              bit_val <= (kind == SYM_D1);
            end
          end
          default: err_ev <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/irpw_rxbuf.sv
// Receive buffer, bit count, full detection and masked compare.
module irpw_rxbuf #(
  parameter int BUF_BITS = 48,
  parameter int SEL_W    = 3,
  localparam int NB      = BUF_BITS / 8,
  localparam int CW      = $clog2(BUF_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                done_ev,
  input  logic                bit_vld,
  input  logic                bit_val,
  input  logic [BUF_BITS-1:0] cmp_val,
  input  logic [SEL_W-1:0]    cmp_sel,
  output logic [BUF_BITS-1:0] data,
  output logic [CW-1:0]       nbits,
  output logic                full_ev,
  output logic                cmp_ev
);
  localparam logic [CW-1:0] LAST_N = CW'(BUF_BITS - 1);
  localparam logic [CW-1:0] FULL_N = CW'(BUF_BITS);

  logic                open;
  logic                chk;
  logic [BUF_BITS-1:0] sel_mask;

  always_comb begin
    sel_mask = '0;
    for (int b = 0; b < NB; b++) begin
      if (int'(cmp_sel) >= b) sel_mask[b*8 +: 8] = 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      nbits   <= '0;
      open    <= 1'b0;
      chk     <= 1'b0;
      full_ev <= 1'b0;
      cmp_ev  <= 1'b0;
    end else begin
      chk     <= 1'b0;
      full_ev <= 1'b0;
      cmp_ev  <= chk && (((data ^ cmp_val) & sel_mask) == '0);
      if (frame_start) begin
        data  <= '0;
        nbits <= '0;
        open  <= 1'b1;
      end else if (bit_vld) begin
        if (!open) begin
          data    <= '0;
          data[0] <= bit_val;
          nbits   <= CW'(1);
          open    <= 1'b1;
          chk     <= 1'b1;
        end else if (nbits < FULL_N) begin
          data[nbits] <= bit_val;
          nbits       <= nbits + CW'(1);
          chk         <= 1'b1;
          if (nbits == LAST_N) full_ev <= 1'b1;
        end
      end
      if (done_ev) open <= 1'b0;
    end
  end
endmodule

// File: rtl/irpw_flags.sv
// Sticky event flags with masked clear and interrupt OR.
module irpw_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] int_en,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      status[k] <= 1'b0;
      else if (ev[k])                  status[k] <= 1'b1;
      else if (clr_stb && clr_mask[k]) status[k] <= 1'b0;
    end
  end

  assign irq = |(status & int_en);
endmodule

// File: rtl/irpw_rx.sv
module irpw_rx
  import irpw_pkg::*;
#(
  parameter int  CNT_W    = 16,
  parameter int  BUF_BITS = 48,
  parameter int  SEL_W    = 3,
  localparam int BITS_W   = $clog2(BUF_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                ir_in,
  input  logic                hdr_en,
  input  logic                sd_en,
  input  logic [CNT_W-1:0]    hdr_min,
  input  logic [CNT_W-1:0]    hdr_max,
  input  logic [CNT_W-1:0]    d0_min,
  input  logic [CNT_W-1:0]    d0_max,
  input  logic [CNT_W-1:0]    d1_min,
  input  logic [CNT_W-1:0]    d1_max,
  input  logic [BUF_BITS-1:0] cmp_val,
  input  logic [SEL_W-1:0]    cmp_sel,
  input  logic [EV_NUM-1:0]   int_en,
  input  logic                clr_stb,
  input  logic [EV_NUM-1:0]   clr_mask,
  output logic [BUF_BITS-1:0] rx_data,
  output logic [BITS_W-1:0]   rx_bits,
  output logic [EV_NUM-1:0]   status,
  output logic                irq
);
  logic [CNT_W-1:0]  meas_w;
  logic              meas_vld;
  logic              done_ev, ovf_ev;
  logic              hdr_ev, spec_ev, data_ev, err_ev;
  logic              bit_vld, bit_val;
  logic              full_ev, cmp_ev;
  logic [EV_NUM-1:0] ev;

  irpw_width_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ir_in(ir_in),
    .hdr_max(hdr_max), .d0_max(d0_max), .d1_max(d1_max),
    .meas_w(meas_w), .meas_vld(meas_vld), .done_ev(done_ev), .ovf_ev(ovf_ev)
  );

  irpw_classify #(.CNT_W(CNT_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .meas_w(meas_w), .meas_vld(meas_vld),
    .done_ev(done_ev), .hdr_en(hdr_en), .sd_en(sd_en),
    .hdr_min(hdr_min), .hdr_max(hdr_max), .d0_min(d0_min), .d0_max(d0_max),
    .d1_min(d1_min), .d1_max(d1_max),
    .hdr_ev(hdr_ev), .spec_ev(spec_ev), .data_ev(data_ev), .err_ev(err_ev),
    .bit_vld(bit_vld), .bit_val(bit_val)
  );

  irpw_rxbuf #(.BUF_BITS(BUF_BITS), .SEL_W(SEL_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_start(hdr_ev), .done_ev(done_ev),
    .bit_vld(bit_vld), .bit_val(bit_val), .cmp_val(cmp_val), .cmp_sel(cmp_sel),
    .data(rx_data), .nbits(rx_bits), .full_ev(full_ev), .cmp_ev(cmp_ev)
  );

  always_comb begin
    ev          = '0;
    ev[EV_DONE] = done_ev;
    ev[EV_HDR]  = hdr_ev;
    ev[EV_DATA] = data_ev;
    ev[EV_SPEC] = spec_ev;
    ev[EV_ERR]  = err_ev;
    ev[EV_FULL] = full_ev;
    ev[EV_CMP]  = cmp_ev;
    ev[EV_OVF]  = ovf_ev;
  end

  irpw_flags #(.N(EV_NUM)) u_flg (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr_stb(clr_stb), .clr_mask(clr_mask),
    .int_en(int_en), .status(status), .irq(irq)
  );
endmodule

// File: rtl/irpw_rx_chk.sv
module irpw_rx_chk #(
  parameter int BUF_BITS = 48,
  parameter int BITS_W   = 6,
  parameter int EVN      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EVN-1:0]    ev,
  input logic [EVN-1:0]    status,
  input logic [EVN-1:0]    int_en,
  input logic [EVN-1:0]    clr_mask,
  input logic              clr_stb,
  input logic              irq,
  input logic [BITS_W-1:0] rx_bits,
  input logic              meas_vld
);
  localparam logic [BITS_W-1:0] FULL_N = BITS_W'(BUF_BITS);
  localparam logic [BITS_W-1:0] LAST_N = BITS_W'(BUF_BITS - 1);

  AST_BITS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bits <= FULL_N);  // R8

  AST_FULL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bits == FULL_N && $past(rx_bits) == LAST_N) |=> status[5]);  // R8

  AST_BITS_AFTER_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bits) |-> $past(meas_vld, 2));  // R3

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq);  // R12

  for (genvar k = 0; k < EVN; k++) begin : g_chk
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev[k] |=> status[k]);  // R11

    AST_FALL_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[k]) |-> $past(clr_stb && clr_mask[k]));  // R11
  end
endmodule

bind irpw_rx irpw_rx_chk #(
  .BUF_BITS(BUF_BITS), .BITS_W(BITS_W), .EVN(irpw_pkg::EV_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev(ev), .status(status), .int_en(int_en),
  .clr_mask(clr_mask), .clr_stb(clr_stb), .irq(irq), .rx_bits(rx_bits),
  .meas_vld(meas_vld)
);

// File: tb/sim_irpw_rx.sv
`timescale 1ns/1ps
module sim_irpw_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        ir_in = 1'b0;
  logic        hdr_en = 1'b1, sd_en = 1'b0;
  logic [15:0] hdr_min = 16'd90, hdr_max = 16'd110;
  logic [15:0] d0_min = 16'd10, d0_max = 16'd14;
  logic [15:0] d1_min = 16'd20, d1_max = 16'd24;
  logic [47:0] cmp_val = '0;
  logic [2:0]  cmp_sel = '0;
  logic [7:0]  int_en = '0;
  logic        clr_stb = 1'b0;
  logic [7:0]  clr_mask = '0;
  logic [47:0] rx_data;
  logic [5:0]  rx_bits;
  logic [7:0]  status;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  irpw_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ir_in(ir_in), .hdr_en(hdr_en),
    .sd_en(sd_en), .hdr_min(hdr_min), .hdr_max(hdr_max), .d0_min(d0_min),
    .d0_max(d0_max), .d1_min(d1_min), .d1_max(d1_max), .cmp_val(cmp_val),
    .cmp_sel(cmp_sel), .int_en(int_en), .clr_stb(clr_stb), .clr_mask(clr_mask),
    .rx_data(rx_data), .rx_bits(rx_bits), .status(status), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] byte_mask(input logic [2:0] s);
    logic [47:0] m = '0;
    for (int b = 0; b < 6; b++) if (int'(s) >= b) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  // one rising edge that closes a width of w ticks
  task automatic sym(input int w);
    repeat (w) @(posedge clk);
    @(negedge clk) ir_in = 1'b1;
    @(posedge clk);
    @(negedge clk) ir_in = 1'b0;
  endtask

  task automatic settle();
    repeat (130) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk);
    clr_stb = 1'b1; clr_mask = 8'hFF;
    @(negedge clk);
    clr_stb = 1'b0; clr_mask = 8'h00;
  endtask

  task automatic frame(input int nb, input logic [63:0] bits, input bit with_hdr);
    sym(5);
    if (with_hdr) sym(100);
    for (int i = 0; i < nb; i++) sym(bits[i] ? 22 : 12);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [47:0] expd;
    logic [63:0] bits;
    logic [7:0]  exps;
    int          nb, expn, last_n;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R13 status", 64'(status), 64'h0);
    chk("R13 rx_bits", 64'(rx_bits), 64'h0);
    chk("R13 rx_data", 64'(rx_data), 64'h0);
    chk("R13 irq", 64'(irq), 64'h0);

    // R2 R3 R8 R9 R12: random headed frames
    last_n = 0;
    for (int f = 0; f < 8; f++) begin
      nb   = $urandom_range(1, 60);
      bits = {$urandom, $urandom};
      expd = '0;
      expn = (nb > 48) ? 48 : nb;
      for (int i = 0; i < expn; i++) expd[i] = bits[i];
      cmp_sel = 3'($urandom_range(0, 7));
      cmp_val = expd ^ ({$urandom, $urandom} & ~byte_mask(cmp_sel));
      int_en  = 8'($urandom);
      clr_all();
      frame(nb, bits, 1'b1);
      settle();
      exps = 8'h47 | ((nb >= 48) ? 8'h20 : 8'h00);
      chk("R3 random rx_data", 64'(rx_data), 64'(expd));
      chk("R8 random rx_bits", 64'(rx_bits), 64'(expn));
      chk("R9 random status", 64'(status), 64'(exps));
      chk("R12 random irq", 64'(irq), 64'(|(exps & int_en)));
      last_n = expn;
    end

    // R6: data before header
    int_en = 8'h00;
    clr_all();
    sym(5); sym(12); settle();
    chk("R6 status", 64'(status), 64'h11);
    chk("R6 rx_bits unchanged", 64'(rx_bits), 64'(last_n));

    // R5 and R2 lower bound: 89 is outside every window
    clr_all();
    sym(5); sym(100); sym(89); settle();
    chk("R5 status", 64'(status), 64'h13);
    chk("R2 header empties buffer", 64'(rx_bits), 64'h0);

    // R1 R2 R3: inclusive window bounds, header at 110
    cmp_val = '1; cmp_sel = 3'd7;
    clr_all();
    sym(5); sym(110); sym(10); sym(14); sym(20); sym(24); settle();
    chk("R1 bounds status", 64'(status), 64'h07);
    chk("R3 bounds rx_data", 64'(rx_data), 64'hC);
    chk("R3 bounds rx_bits", 64'(rx_bits), 64'd4);

    // R4: special symbol, header disabled
    hdr_en = 1'b0; sd_en = 1'b1; cmp_val = '0; cmp_sel = 3'd0;
    clr_all();
    sym(5); sym(100); sym(22); settle();
    chk("R4 status", 64'(status), 64'h0D);
    chk("R4 rx_bits", 64'(rx_bits), 64'd1);
    chk("R4 rx_data", 64'(rx_data), 64'd1);
    hdr_en = 1'b1; sd_en = 1'b0;

    // R9: mismatch inside selected byte
    cmp_val = 48'hA4; cmp_sel = 3'd0;
    clr_all();
    frame(8, 64'hA5, 1'b1); settle();
    chk("R9 mismatch status", 64'(status), 64'h07);

    // R8 R9: overfull frame, mismatch in top byte with all bytes selected
    bits = {$urandom, $urandom};
    expd = bits[47:0];
    cmp_val = expd ^ 48'h8000_0000_0000; cmp_sel = 3'd5;
    clr_all();
    frame(52, bits, 1'b1); settle();
    chk("R8 full status", 64'(status), 64'h27);
    chk("R8 full rx_bits", 64'(rx_bits), 64'd48);
    chk("R8 extra bits ignored", 64'(rx_data), 64'(expd));

    // R11: masked clear
    @(negedge clk); clr_stb = 1'b1; clr_mask = 8'h01;
    @(negedge clk); clr_stb = 1'b0; clr_mask = 8'h00;
    chk("R11 masked clear", 64'(status), 64'h26);

    // R12: enables
    int_en = 8'h20; @(negedge clk);
    chk("R12 irq enabled", 64'(irq), 64'h1);
    int_en = 8'h01; @(negedge clk);
    chk("R12 irq masked", 64'(irq), 64'h0);
    int_en = 8'h00;

    // R7: completion only after count exceeds 110
    clr_all();
    frame(2, 64'h1, 1'b1);
    repeat (100) @(posedge clk); @(negedge clk);
    chk("R7 not yet complete", 64'(status[0]), 64'h0);
    repeat (20) @(posedge clk); @(negedge clk);
    chk("R7 complete", 64'(status[0]), 64'h1);

    // R10: wrap with maxima at the top
    hdr_max = 16'hFFFF; d0_max = 16'hFFFF; d1_max = 16'hFFFF;
    clr_all();
    sym(5);
    repeat (65540) @(posedge clk); @(negedge clk);
    chk("R10 overflow flag", 64'(status[7]), 64'h1);
    chk("R10 no completion", 64'(status[0]), 64'h0);
    hdr_max = 16'd110; d0_max = 16'd14; d1_max = 16'd24;
    settle();

    done_flag = 1;
    report();
  end
endmodule